// File: doc/BRIEF.md
# Linear Systolic Matrix Multiplier

This block multiplies an N×N integer matrix X by an N×N weight matrix W using a chain of N identical cells. Cell j keeps column j of W in a small local RAM, which is written through a shared load bus with one enable bit per cell. X is streamed in element by element in row-major order with a valid flag. A head controller tags each element with its column index inside the row and with first and last markers. Element, index and markers then travel right together through two register stages per cell. Each cell uses the forwarded index to read the weight for the current element.

Each cell performs one signed multiply-accumulate per accepted element. The accumulator restarts on the first element of a row, so rows may follow each other with no idle cycle. On the last element of a row the finished inner product y(i,j) is placed on a shared result chain. That chain advances one cell per cycle. The two-stage spacing of the input stream staggers completions by two cycles per cell, so results reach the right end as one unbroken row-major stream. The input may pause at any point, and the weights stay valid across rows, products and resets.

Top module: `linmm_top`

## Requirements
- R1: Each result equals the sum over k of X(i,k)·W(k,j), with inputs and weights read as signed two's complement of DW bits and the result given as a signed value of AW = 2·DW + clog2(N) bits.
- R2: Exactly one result leaves per (row, column) pair. Results leave in row-major order: row by row, and column 0 to N-1 within a row.
- R3: y(i,j) is presented with yValid high exactly N + j cycles after the rising clock edge that accepts the last element (column N-1) of row i.
- R4: The accumulation of a row starts fresh from that row's first element. Rows fed back to back, with no idle cycle between them, produce correct, independent results.
- R5: Cycles with xValid low are skipped. Their xData value has no effect on any result, and row framing resumes where it stopped.
- R6: A cycle with bit j of wrEn high writes wrData into W(wrAddr, j) at the clock edge. Columns whose enable bit is low keep their contents.
- R7: While rstN is low, yValid is low. After reset the element counter starts again at column 0, so a partly fed row is discarded, while the stored weights are kept.
- R8: A cell only places a result into a slot of the result chain that holds no valid result. No result is ever lost or overwritten.
- R9: The element, its column index and its row markers reach cell j+1 exactly two cycles after they reach cell j. The index never exceeds N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | N | Weight write enable, bit j selects the column held by cell j |
| wrAddr | input | clog2(N) | Row index k of the weight being written |
| wrData | input | DW | Signed weight value |
| xValid | input | 1 | xData carries the next element of X |
| xData | input | DW | Signed element of X, row-major order |
| yValid | output | 1 | yData carries the next element of Y |
| yData | output | AW | Signed element of Y, row-major order |

## Verification
A corrupted column index or a misaligned stage stage in the input chain shows up as wrong values, but only in the columns served by cells downstream of the fault. These become visible N+j cycles after the affected row ends. If the accumulator fails to clear, every row after the first carries a stale sum. This appears at the first output of the second row, so back-to-back rows are the decisive stimulus. A collision or a wrong insertion time on the result chain shows up as a missing, duplicated or mistimed yValid pulse. The bench compares every cycle against a per-cycle expected schedule, so such faults are flagged on the exact cycle they occur, not only as a wrong count at the end.

// File: rtl/linmm_pkg.sv
package linmm_pkg;

  // Row framing strobes that travel with each element of X.
  typedef struct packed {
    logic vld;    // element present in this slot
    logic first;  // column 0 of its row
    logic last;   // column N-1 of its row
  } strobe_t;

endpackage

// File: rtl/linmm_ctrl.sv
module linmm_ctrl
  import linmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          xValid,
  input  logic [DW-1:0] xData,
  output strobe_t       headStb,
  output logic [IW-1:0] headAddr,
  output logic [DW-1:0] headX
);

  localparam logic [IW-1:0] LastIdx = IW'(N - 1);

  logic [IW-1:0] kCnt;
  logic          atFirst;
  logic          atLast;

  assign atFirst = (kCnt == '0);
  assign atLast  = (kCnt == LastIdx);

  // Column counter inside the current row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kCnt <= '0;
    end else if (xValid) begin
      kCnt <= atLast ? '0 : kCnt + 1'b1;
    end
  end

  // Stream head register: strobes carry reset, payload does not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headStb <= '0;
    end else begin
      headStb.vld   <= xValid;
      headStb.first <= xValid && atFirst;
      headStb.last  <= xValid && atLast;
    end
  end

  always_ff @(posedge clk) begin
    headAddr <= kCnt;
    headX    <= xData;
  end

  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    headStb.vld |-> (int'(headAddr) < N));

  // R4
  row_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (headStb.vld && !headStb.last) |=> !(headStb.vld && headStb.first));

endmodule

// File: rtl/linmm_cell.sv
module linmm_cell
  import linmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = $clog2(N),
  localparam int PW = 2 * DW,
  localparam int AW = 2 * DW + $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [IW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  strobe_t       inStb,
  input  logic [IW-1:0] inAddr,
  input  logic [DW-1:0] inX,
  input  logic          yInVld,
  input  logic [AW-1:0] yInData,
  output logic          yOutVld,
  output logic [AW-1:0] yOutData
);

  // Local weight column
  logic signed [DW-1:0] wMem [N];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      wMem[wrAddr] <= wrData;
    end
  end

  logic signed [DW-1:0] wSel;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prodExt;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] accNext;
  logic                 insert;

  assign wSel    = wMem[inAddr];
  assign prod    = $signed(inX) * wSel;
  assign prodExt = {{(AW - PW){prod[PW-1]}}, prod};
  assign accNext = (inStb.first ? '0 : acc) + prodExt;
  assign insert  = inStb.vld && inStb.last;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (inStb.vld) begin
      acc <= accNext;
    end
  end

  // Result chain slot owned by this cell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yOutVld  <= 1'b0;
      yOutData <= '0;
    end else if (insert) begin
      yOutVld  <= 1'b1;
      yOutData <= accNext;
    end else begin
      yOutVld  <= yInVld;
      yOutData <= yInData;
    end
  end

  // R8
  no_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    insert |-> !yInVld);

endmodule

// File: rtl/linmm_array.sv
module linmm_array
  import linmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = $clog2(N),
  localparam int AW = 2 * DW + $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  wrEn,
  input  logic [IW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  strobe_t       headStb,
  input  logic [IW-1:0] headAddr,
  input  logic [DW-1:0] headX,
  output logic          yValid,
  output logic [AW-1:0] yData
);

  // Input stream as seen by each cell
  strobe_t       stb [N];
  logic [IW-1:0] adr [N];
  logic [DW-1:0] xs  [N];

  // Result chain, slot j feeds cell j
  logic          yV [N+1];
  logic [AW-1:0] yD [N+1];

  assign stb[0] = headStb;
  assign adr[0] = headAddr;
  assign xs[0]  = headX;
  assign yV[0]  = 1'b0;
  assign yD[0]  = '0;

  // Two register stages between neighbouring cells
  for (genvar j = 0; j < N - 1; j++) begin : g_hop
    strobe_t       aStb, bStb;
    logic [IW-1:0] aAdr, bAdr;
    logic [DW-1:0] aX, bX;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aStb <= '0;
        bStb <= '0;
      end else begin
        aStb <= stb[j];
        bStb <= aStb;
      end
    end

    always_ff @(posedge clk) begin
      aAdr <= adr[j];
      bAdr <= aAdr;
      aX   <= xs[j];
      bX   <= aX;
    end

    assign stb[j+1] = bStb;
    assign adr[j+1] = bAdr;
    assign xs[j+1]  = bX;

    // R9
    stream_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[j].vld |-> ##2 (stb[j+1].vld && adr[j+1] == $past(adr[j], 2)
                          && stb[j+1].last == $past(stb[j].last, 2)));
  end

  for (genvar j = 0; j < N; j++) begin : g_cell
    linmm_cell #(.N(N), .DW(DW)) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (wrEn[j]),
      .wrAddr  (wrAddr),
      .wrData  (wrData),
      .inStb   (stb[j]),
      .inAddr  (adr[j]),
      .inX     (xs[j]),
      .yInVld  (yV[j]),
      .yInData (yD[j]),
      .yOutVld (yV[j+1]),
      .yOutData(yD[j+1])
    );
  end

  assign yValid = yV[N];
  assign yData  = yD[N];

endmodule

// File: rtl/linmm_top.sv
module linmm_top
  import linmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int IW = $clog2(N),
  localparam int AW = 2 * DW + $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  wrEn,
  input  logic [IW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          xValid,
  input  logic [DW-1:0] xData,
  output logic          yValid,
  output logic [AW-1:0] yData
);

  strobe_t       headStb;
  logic [IW-1:0] headAddr;
  logic [DW-1:0] headX;

  linmm_ctrl #(.N(N), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .xValid  (xValid),
    .xData   (xData),
    .headStb (headStb),
    .headAddr(headAddr),
    .headX   (headX)
  );

  linmm_array #(.N(N), .DW(DW)) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .headStb (headStb),
    .headAddr(headAddr),
    .headX   (headX),
    .yValid  (yValid),
    .yData   (yData)
  );

endmodule

// File: tb/linmm_top_bench.sv
`timescale 1ns/1ps
module linmm_top_bench;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = $clog2(N);
  localparam int AW = 2 * DW + $clog2(N);

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  wrEn;
  logic [IW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          xValid;
  logic [DW-1:0] xData;
  logic          yValid;
  logic [AW-1:0] yData;

  always #2.5 clk = ~clk;

  linmm_top #(.N(N), .DW(DW)) u_linmm_top (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .xValid(xValid),
    .xData (xData),
    .yValid(yValid),
    .yData (yData)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;
  bit finished = 0;

  // Reference model state
  int wRef [N][N];
  int rowAcc [N];
  int kRef = 0;
  int expT [$];
  int expV [$];

  // Behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      kRef = 0;
      expT.delete();
      expV.delete();
    end else if (xValid) begin
      for (int j = 0; j < N; j++) begin
        if (kRef == 0) rowAcc[j] = 0;
        rowAcc[j] += int'($signed(xData)) * wRef[kRef][j];
      end
      if (kRef == N - 1) begin
        // R3: y(i,j) expected N+j cycles after this edge
        for (int j = 0; j < N; j++) begin
          expT.push_back(cyc + N + j);
          expV.push_back(rowAcc[j]);
        end
        kRef = 0;
      end else begin
        kRef++;
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (yValid) begin
        nChk++;
        if (expT.size() == 0) begin
          nBad++;
          $display("FAIL R2 extra result: actual=%0d expected=none", $signed(yData));
        end else begin
          int t;
          int v;
          t = expT.pop_front();
          v = expV.pop_front();
          if (t != cyc) begin
            nBad++;
            $display("FAIL R3 result timing: actual=%0d expected=%0d", cyc, t);
          end
          // R1 value, R9 alignment of index and data across cells
          if (int'($signed(yData)) != v) begin
            nBad++;
            $display("FAIL R1 result value: actual=%0d expected=%0d", $signed(yData), v);
          end
        end
      end else if (expT.size() != 0 && expT[0] <= cyc) begin
        nChk++;
        nBad++;
        $display("FAIL R8 result missing: actual=none expected=%0d at %0d", expV[0], expT[0]);
        void'(expT.pop_front());
        void'(expV.pop_front());
      end
    end
  end

  task automatic loadCell(input int c, input int r, input int v);
    @(negedge clk);
    wrEn   = N'(1) << c;
    wrAddr = IW'(r);
    wrData = DW'(v);
    wRef[r][c] = v;
  endtask

  task automatic loadAll(input int seed);
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++)
        loadCell(c, r, ((r * 7 + c * 13 + seed * 31) % 255) - 127);
    @(negedge clk);
    wrEn = '0;
  endtask

  task automatic sendX(input int v);
    @(negedge clk);
    xValid = 1'b1;
    xData  = DW'(v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xValid = 1'b0;
      xData  = DW'(cyc * 29 + 3);
    end
  endtask

  function automatic int xGen(input int i, input int k, input int seed);
    return ((i * 37 + k * 11 + seed * 5) % 255) - 127;
  endfunction

  initial begin
    rstN = 1'b0; wrEn = '0; wrAddr = '0; wrData = '0;
    xValid = 1'b0; xData = '0;
    // R7: output quiet under reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      nChk++;
      if (yValid !== 1'b0) begin
        nBad++;
        $display("FAIL R7 yValid in reset: actual=%b expected=0", yValid);
      end
    end
    rstN = 1'b1;
    loadAll(1);

    // R1 R2 R4: three rows back to back
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < N; k++) sendX(xGen(i, k, 1));
    idle(3 * N);

    // R1 boundary: extreme magnitudes
    for (int c = 0; c < N; c++)
      for (int r = 0; r < N; r++) loadCell(c, r, (c == 1) ? 127 : -128);
    @(negedge clk); wrEn = '0;
    for (int k = 0; k < N; k++) sendX(-128);
    for (int k = 0; k < N; k++) sendX(127);
    for (int k = 0; k < N; k++) sendX((k % 2 == 0) ? -128 : 127);
    idle(3 * N);

    // R5: gaps with junk on xData while xValid is low
    loadAll(2);
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < N; k++) begin
        sendX(xGen(i, k, 2));
        idle((i + k) % 3);
      end
    idle(3 * N);

    // R6: rewrite one column only, the others must keep their weights
    for (int r = 0; r < N; r++) loadCell(2, r, 50 - 17 * r);
    @(negedge clk); wrEn = '0;
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < N; k++) sendX(xGen(i, k, 3));
    idle(3 * N);

    // R7: reset in the middle of a row, framing restarts, weights kept
    sendX(99); sendX(-45);
    idle(1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    nChk++;
    if (yValid !== 1'b0) begin
      nBad++;
      $display("FAIL R7 yValid in reset: actual=%b expected=0", yValid);
    end
    rstN = 1'b1;
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < N; k++) sendX(xGen(i, k, 4));
    idle(4 * N);

    nChk++;
    if (expT.size() != 0) begin
      nBad++;
      $display("FAIL R2 results outstanding: actual=%0d expected=0", expT.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      nChk++;
      nBad++;
      $display("FAIL R2 watchdog expired: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule